// File: doc/BRIEF.md
# Wide event to packet serializer

The block turns one wide event word into a stream of 16-bit debug flits. A producer presents the event on `data`, together with its own address on `id` and a destination on `dest`, and raises `event_available`. The block copies all three inputs in the idle cycle where it sees the strobe. It then sends the event as one or more EVENT packets over a valid/ready/last flit interface. When the last flit of the last packet has been accepted, it pulses `event_consumed` for one cycle.

Each packet starts with three header flits: the destination, then the source, then a kind word. The payload follows the header. A packet holds at most `MAX_PKT_LEN-3` payload words. The event is cut into 16-bit words, starting at its least significant end. If the event needs more than one packet, every packet but the final one carries subtype 1 and is completely filled. The final packet carries subtype 0 and holds whatever words remain.

The controller is a Moore machine with six states:
- ST_IDLE waits for a strobe. ST_IDLE goes to ST_DEST when `event_available` is high.
- ST_DEST, ST_SRC and ST_KIND send the three header flits. Each one moves to the next state on a handshake.
- ST_KIND goes to ST_BODY on a handshake.
- ST_BODY stays in ST_BODY while the packet has more payload words. At the end of a packet it goes back to ST_DEST if event words remain. After the last word of the event it goes to ST_DONE.
- ST_DONE drives `event_consumed` and always goes back to ST_IDLE after one cycle.

Top module: `evpk_serializer`

## Requirements
- R1: After reset, `out_valid` and `event_consumed` are low.
- R2: Each packet begins with three header flits, in this order: `dest`, then `id`, then a kind word. In the kind word, bits 15:14 hold 2'b10 (EVENT), bits 13:10 hold the subtype, and all other bits are zero.
- R3: A packet carries at most `MAX_PKT_LEN-3` payload words. Every packet except the final one is full. The total number of flits sent for an event equals the count that follows from this rule.
- R4: The subtype is 1 in every packet except the final one. The final packet has subtype 0.
- R5: Across the whole event, payload word k has data byte 2k in bits 7:0 and data byte 2k+1 in bits 15:8. Byte 0 is `data[7:0]`.
- R6: When the data width is not a multiple of 16, the bits of the final word that lie above the data width are zero.
- R7: `out_last` is high only on the last payload flit of each packet.
- R8: While `out_valid` is high and `out_ready` is low, the flit and `out_last` stay unchanged, and `out_valid` stays high.
- R9: `event_consumed` is high for exactly one cycle. That cycle follows the acceptance of the final flit of the final packet. It is never high while the event is still being sent.
- R10: `data`, `id` and `dest` are captured in the idle cycle where `event_available` is seen. Changing these inputs later has no effect on the packets of that event.
- R11: While idle with `event_available` low, no flit is sent. A low `overflow` input changes nothing.
- R12: A new event starts only from ST_IDLE, which is entered after ST_DONE. If `event_available` is dropped when `event_consumed` is seen, no further packet follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| id | input | 16 | Source address of this module |
| dest | input | 16 | Destination address for the packets |
| data | input | DATA_W | Event word |
| overflow | input | 1 | Overflow indication (no effect when low) |
| event_available | input | 1 | An event is ready to be taken |
| event_consumed | output | 1 | One-cycle pulse after the event has been fully sent |
| out_flit | output | 16 | Flit data |
| out_valid | output | 1 | Flit is valid |
| out_last | output | 1 | Last flit of the current packet |
| out_ready | input | 1 | Sink accepts the flit |

## Verification
The bench sends events with three data patterns:
- An incrementing byte pattern shows whether bytes are swapped within a word and whether words are in the right order.
- An all-ones pattern shows whether the padding bits of the final word come out zero, as opposed to copying neighbouring data.
- An alternating pattern is sent against a sink that stalls at regular intervals. During that event the inputs are inverted right after the first handshake. This separates a correct hold under backpressure, and a correct one-time capture, from designs that re-read the inputs.

A 6-word event with 5-word packets splits into one full packet and a one-word tail. This exercises the subtype switch and the `out_last` placement across a packet boundary.

// File: rtl/evpk_pkg.sv
package evpk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEST,
        ST_SRC,
        ST_KIND,
        ST_BODY,
        ST_DONE
    } evpk_state_e;

    localparam logic [1:0] KIND_EVENT = 2'b10;
    localparam logic [3:0] SUB_MORE   = 4'd1;
    localparam logic [3:0] SUB_FINAL  = 4'd0;

    function automatic logic [15:0] kind_word(input logic [3:0] sub);
        return {KIND_EVENT, sub, 10'b0};
    endfunction

endpackage

// File: rtl/evpk_word_sel.sv
module evpk_word_sel #(
    parameter int DATA_W = 88,
    parameter int NWORDS = 6,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] data_in,
    input  logic [IDX_W-1:0]  idx,
    output logic [15:0]       word
);
    localparam int PAD_W = NWORDS * 16;

    logic [PAD_W-1:0] held_q;
    logic [PAD_W-1:0] padded;
    logic [15:0]      words [NWORDS];

    always_comb begin
        padded = '0;
        padded[DATA_W-1:0] = data_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            held_q <= '0;
        else if (load)
            held_q <= padded;
    end

    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        assign words[g] = held_q[g*16 +: 16];
    end

    assign word = words[idx];

endmodule

// File: rtl/evpk_flit_mux.sv
module evpk_flit_mux
    import evpk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [15:0] id_in,
    input  logic [15:0] dest_in,
    input  evpk_state_e state,
    input  logic        final_pkt,
    input  logic [15:0] word,
    output logic [15:0] flit
);
    logic [15:0] id_q;
    logic [15:0] dest_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            id_q   <= '0;
            dest_q <= '0;
        end else if (load) begin
            id_q   <= id_in;
            dest_q <= dest_in;
        end
    end

    always_comb begin
        unique case (state)
            ST_DEST: flit = dest_q;
            ST_SRC:  flit = id_q;
            ST_KIND: flit = kind_word(final_pkt ? SUB_FINAL : SUB_MORE);
            ST_BODY: flit = word;
            default: flit = '0;
        endcase
    end

endmodule

// File: rtl/evpk_ctrl.sv
module evpk_ctrl
    import evpk_pkg::*;
#(
    parameter int NWORDS  = 6,
    parameter int PAY_MAX = 5,
    parameter int IDX_W   = 3,
    parameter int PCNT_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             event_available,
    input  logic             overflow,
    input  logic             out_ready,
    output evpk_state_e      state,
    output logic [IDX_W-1:0] widx,
    output logic             final_pkt,
    output logic             load,
    output logic             out_valid,
    output logic             out_last,
    output logic             event_consumed
);
    evpk_state_e       state_q, state_d;
    logic [PCNT_W-1:0] pcnt_q;
    logic [IDX_W-1:0]  widx_q;
    logic              last_word;
    logic              pkt_end;
    logic              beat;

    assign last_word = (widx_q == IDX_W'(NWORDS - 1));
    assign pkt_end   = last_word || (pcnt_q == PCNT_W'(PAY_MAX - 1));
    assign final_pkt = (int'(widx_q) + PAY_MAX) >= NWORDS;
    assign beat      = out_valid && out_ready;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (event_available) state_d = ST_DEST;
            ST_DEST: if (out_ready) state_d = ST_SRC;
            ST_SRC:  if (out_ready) state_d = ST_KIND;
            ST_KIND: if (out_ready) state_d = ST_BODY;
            ST_BODY: if (out_ready) begin
                if (last_word)    state_d = ST_DONE;
                else if (pkt_end) state_d = ST_DEST;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            widx_q  <= '0;
            pcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            if (load) begin
                widx_q <= '0;
                pcnt_q <= '0;
            end else if (state_q == ST_BODY && beat) begin
                if (!last_word) widx_q <= widx_q + 1'b1;
                pcnt_q <= pkt_end ? '0 : pcnt_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        out_valid      = 1'b0;
        out_last       = 1'b0;
        event_consumed = 1'b0;
        load           = 1'b0;
        unique case (state_q)
            ST_IDLE: load = event_available;
            ST_DEST, ST_SRC, ST_KIND: out_valid = 1'b1;
            ST_BODY: begin
                out_valid = 1'b1;
                out_last  = pkt_end;
            end
            ST_DONE: event_consumed = 1'b1;
            default: ;
        endcase
    end

    assign state = state_q;
    assign widx  = widx_q;

    AST_CONS_ONE:   assert property (@(posedge clk) disable iff (!rst_n) event_consumed |=> !event_consumed); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (state_q == ST_IDLE && !event_available && !overflow) |=> !out_valid); // R11
    AST_IDX_RANGE:  assert property (@(posedge clk) disable iff (!rst_n) int'(widx_q) < NWORDS); // R5
    AST_PCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) int'(pcnt_q) < PAY_MAX); // R3

endmodule

// File: rtl/evpk_serializer.sv
module evpk_serializer
    import evpk_pkg::*;
#(
    parameter int DATA_W      = 88,
    parameter int MAX_PKT_LEN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       id,
    input  logic [15:0]       dest,
    input  logic [DATA_W-1:0] data,
    input  logic              overflow,
    input  logic              event_available,
    output logic              event_consumed,
    output logic [15:0]       out_flit,
    output logic              out_valid,
    output logic              out_last,
    input  logic              out_ready
);
    localparam int NWORDS  = (DATA_W + 15) / 16;
    localparam int PAY_MAX = MAX_PKT_LEN - 3;
    localparam int IDX_W   = (NWORDS > 1) ? $clog2(NWORDS) : 1;
    localparam int PCNT_W  = (PAY_MAX > 1) ? $clog2(PAY_MAX) : 1;

    evpk_state_e      state;
    logic [IDX_W-1:0] widx;
    logic             final_pkt;
    logic             load;
    logic [15:0]      word;

    evpk_ctrl #(
        .NWORDS (NWORDS),
        .PAY_MAX(PAY_MAX),
        .IDX_W  (IDX_W),
        .PCNT_W (PCNT_W)
    ) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .event_available(event_available),
        .overflow       (overflow),
        .out_ready      (out_ready),
        .state          (state),
        .widx           (widx),
        .final_pkt      (final_pkt),
        .load           (load),
        .out_valid      (out_valid),
        .out_last       (out_last),
        .event_consumed (event_consumed)
    );

    evpk_word_sel #(
        .DATA_W(DATA_W),
        .NWORDS(NWORDS),
        .IDX_W (IDX_W)
    ) u_word_sel (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .data_in(data),
        .idx    (widx),
        .word   (word)
    );

    evpk_flit_mux u_flit_mux (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .id_in    (id),
        .dest_in  (dest),
        .state    (state),
        .final_pkt(final_pkt),
        .word     (word),
        .flit     (out_flit)
    );

    AST_FLIT_HOLD:       assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_ready) |=> (out_valid && $stable(out_flit) && $stable(out_last))); // R8
    AST_CONS_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n) event_consumed |-> $past(out_valid && out_ready && out_last)); // R9

endmodule

// File: tb/evpk_serializer_bench.sv
module evpk_serializer_bench;
    localparam int DW   = 88;
    localparam int MPL  = 8;
    localparam int NW   = (DW + 15) / 16;
    localparam int PAY  = MPL - 3;
    localparam int NP   = (NW + PAY - 1) / PAY;
    localparam int MAXF = NP * MPL;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [15:0]   id = '0;
    logic [15:0]   dest = '0;
    logic [DW-1:0] data = '0;
    logic          overflow = 1'b0;
    logic          event_available = 1'b0;
    logic          event_consumed;
    logic [15:0]   out_flit;
    logic          out_valid;
    logic          out_last;
    logic          out_ready = 1'b0;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    evpk_serializer #(.DATA_W(DW), .MAX_PKT_LEN(MPL)) u_evpk_serializer (
        .clk(clk), .rst_n(rst_n), .id(id), .dest(dest), .data(data),
        .overflow(overflow), .event_available(event_available),
        .event_consumed(event_consumed), .out_flit(out_flit),
        .out_valid(out_valid), .out_last(out_last), .out_ready(out_ready)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] byte_of(input logic [DW-1:0] d, input int i);
        logic [DW-1:0] t;
        t = d >> (8 * i);
        return (8 * i < DW) ? t[7:0] : 8'h00;
    endfunction

    task automatic t_reset();
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 valid after reset", 32'(out_valid), 0);
        chk(event_consumed == 1'b0, "R1 consumed after reset", 32'(event_consumed), 0);
    endtask

    task automatic t_idle_quiet();
        bit seen = 0;
        event_available = 1'b0;
        overflow = 1'b0;
        out_ready = 1'b1;
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            if (out_valid || event_consumed) seen = 1;
        end
        chk(!seen, "R11 no flit while idle", 32'(seen), 0);
    endtask

    task automatic run_event(input logic [DW-1:0] d, input logic [15:0] i_id, input logic [15:0] i_dest,
                             input bit stall, input bit scramble);
        logic [15:0] ef [MAXF];
        bit          el [MAXF];
        int          nf = 0;
        int          got = 0;
        int          wd = 0;
        bit          held_v = 0;
        logic [15:0] held_f = '0;
        bit          held_l = 0;
        bit          rdy;
        bit          quiet;
        for (int p = 0; p < NP; p++) begin
            int nwp = (NW - p * PAY < PAY) ? NW - p * PAY : PAY;
            logic [3:0] sub = (p < NP - 1) ? 4'd1 : 4'd0;
            ef[nf] = i_dest; el[nf] = 0; nf++;
            ef[nf] = i_id;   el[nf] = 0; nf++;
            ef[nf] = {2'b10, sub, 10'b0}; el[nf] = 0; nf++;
            for (int w = 0; w < nwp; w++) begin
                int k = p * PAY + w;
                ef[nf] = {byte_of(d, 2 * k + 1), byte_of(d, 2 * k)};
                el[nf] = (w == nwp - 1);
                nf++;
            end
        end
        @(negedge clk);
        data = d; id = i_id; dest = i_dest; event_available = 1'b1;
        while (got < nf && wd < 2000) begin
            @(negedge clk);
            wd++;
            rdy = stall ? ((wd % 3) != 1) : 1'b1;
            out_ready = rdy;
            if (event_consumed) chk(0, "R9 early consumed", 1, 0);
            if (held_v) begin
                chk(out_valid && out_flit == held_f && out_last == held_l, "R8 hold under stall",
                    {15'b0, out_last, out_flit}, {15'b0, held_l, held_f});
                held_v = 0;
            end
            if (out_valid) begin
                if (rdy) begin
                    if (got % MPL < 3)
                        chk(out_flit == ef[got], "R2 R4 header flit", 32'(out_flit), 32'(ef[got]));
                    else if (got == nf - 1)
                        chk(out_flit == ef[got], "R5 R6 final word", 32'(out_flit), 32'(ef[got]));
                    else
                        chk(out_flit == ef[got], "R5 payload word", 32'(out_flit), 32'(ef[got]));
                    chk(out_last == el[got], "R7 R3 last flag", 32'(out_last), 32'(el[got]));
                    got++;
                    if (scramble && got == 1) begin
                        data = ~d; id = ~i_id; dest = ~i_dest; // R10
                    end
                end else begin
                    held_v = 1; held_f = out_flit; held_l = out_last;
                end
            end
        end
        chk(got == nf, "R3 flit count", 32'(got), 32'(nf));
        @(negedge clk);
        chk(event_consumed == 1'b1, "R9 consumed pulse", 32'(event_consumed), 1);
        chk(out_valid == 1'b0, "R3 no extra flit", 32'(out_valid), 0);
        event_available = 1'b0;
        @(negedge clk);
        chk(event_consumed == 1'b0, "R9 pulse width", 32'(event_consumed), 0);
        quiet = 1;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            if (out_valid) quiet = 0;
        end
        chk(quiet, "R12 no restart", 32'(!quiet), 0);
    endtask

    task automatic t_incrementing();
        logic [DW-1:0] d = '0;
        for (int i = 0; i < DW / 8; i++) d[8*i +: 8] = 8'(i + 1);
        run_event(d, 16'h0001, 16'h0000, 0, 0);
    endtask

    task automatic t_all_ones();
        run_event({DW{1'b1}}, 16'h1234, 16'hbeef, 0, 0); // R6 padding must stay zero
    endtask

    task automatic t_stall_scramble();
        logic [DW-1:0] d = '0;
        for (int i = 0; i < DW / 8; i++) d[8*i +: 8] = (i % 2 == 0) ? 8'ha5 : 8'h3c;
        run_event(d, 16'h00c7, 16'h0042, 1, 1); // R8 R10
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_idle_quiet();
        t_incrementing();
        t_all_ones();
        t_stall_scramble();
        t_incrementing();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule